// File: doc/BRIEF.md
# Multiplier-free adaptive FIR filter with bit-serial table lookup

This block is a four-tap adaptive FIR filter. It forms its output without a multiplier. A register table holds every subset sum of the tap weights, 2^N entries in all. The filter walks the delay-line samples one bit position at a time, from the most significant bit down. At each step, the bit of every tap at that position forms the table address. The selected entry is folded into a running sum. The sum is doubled at every step, and the entry for the sign bit is subtracted. After B steps the sum is the exact inner product of the weights and the delay line. From it the block produces the output y and the error e = d − y. The weights are then trained with the least-mean-square rule, using a power-of-two step size.

The weight update runs in the same bit cycles as the filtering. Each tap builds the product of the previous error and its previous sample by shift-and-add over the same bit counter. At the end of the sample, every weight is written in one step, with saturation. At the start of the next sample, every table entry is rebuilt from the new weights in one step. As a result, the weights used for sample n+1 include the correction from the error of sample n−1: the adaptation delay is one sample. The fast bit clock is modelled as the ordinary clock. The delay line, weights and table change only once per sample.

A small state machine drives the block. ST_IDLE waits for a sample. ST_LOAD shifts the delay line, rebuilds the table and snapshots the update operands. ST_ACCUM runs B bit steps. ST_FINISH writes y, e and the weights, and pulses done. The transitions are: IDLE→LOAD on x_valid, LOAD→ACCUM always, ACCUM→ACCUM while bits remain, ACCUM→FINISH after bit 0, and FINISH→IDLE always.

Top module: `dalms_filter`

## Requirements
- R1: In ST_IDLE, a high d_valid stores d_in as the held desired sample. A high x_valid stores x_in and mu_k and starts a sample. A sample accepted with d_valid low uses the last held desired value.
- R2: done is high for exactly one cycle. Counting the rising edge that accepts x_valid as edge 1, done is visible after edge B+3 (edge 11 for B = 8). The block spends B+2 cycles busy per sample.
- R3: The output is y = sat_W((Σ w_i·x(n−i)) >>> (B−1)), printed as a signed W-bit value with F = 12 fractional bits. Tap 0 holds the newest sample, and its bit drives address bit 0 of the table. Samples not yet received count as zero.
- R4: The error is e = sat_W(d·2^(F−B+1) − y), a signed W-bit value.
- R5: While sample n is processed, each weight becomes sat_W(w_i + ((e(n−1)·x(n−1−i)) >>> (B−1+k))), where k is the mu_k value accepted with sample n and the shift rounds toward minus infinity. The new weights first affect sample n+1.
- R6: Weight updates saturate at the W-bit signed limits, −32768 and 32767.
- R7: The output y saturates at the W-bit signed limits instead of wrapping.
- R8: After reset, y_out and e_out are 0, done is low, and all weights and delay-line taps are 0.
- R9: x_valid, x_in, d_valid, d_in and mu_k are ignored outside ST_IDLE. Toggling them while busy leaves y, e and later samples unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (bit-cycle enable folded in) |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_in | input | 8 | Input sample, signed, 7 fractional bits |
| x_valid | input | 1 | Starts a sample when idle |
| d_in | input | 8 | Desired sample, signed, 7 fractional bits |
| d_valid | input | 1 | Stores d_in when idle |
| mu_k | input | 3 | Step-size exponent k, μ = 2^−k |
| y_out | output | 16 | Filter output, signed, 12 fractional bits |
| e_out | output | 16 | Error output, signed, 12 fractional bits |
| done | output | 1 | One-cycle strobe, y_out/e_out valid |

## Verification
A stale or partly rebuilt table entry corrupts y_out on the very sample that uses it. Because e_out is derived from y_out, the error is wrong in the same done cycle. A bad weight update cannot be seen at once. It first shows up in y_out one sample later, because of the one-sample adaptation delay. The bench therefore compares every sample against a running behavioural model, so a drift in the weights is caught on the next done pulse. A fault in the bit counter or the state sequence moves the done pulse away from edge B+3, and the per-cycle strobe comparison catches that within a single sample.

// File: rtl/dalms_pkg.sv
package dalms_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ACCUM,
        ST_FINISH
    } dalms_state_e;

    // Clamp a signed value to the range of a 'bits'-wide two's complement word.
    function automatic logic signed [31:0] clip(input logic signed [31:0] v, input int bits);
        logic signed [31:0] hi;
        logic signed [31:0] lo;
        hi = (32'sd1 <<< (bits - 1)) - 32'sd1;
        lo = -(32'sd1 <<< (bits - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/dalms_table.sv
module dalms_table #(
    parameter int N  = 4,
    parameter int W  = 16,
    parameter int TW = 18
) (
    input  logic [N*W-1:0]           w_flat,
    output logic [(1<<N)*TW-1:0]     tbl_flat
);
    localparam int NE = 1 << N;

    // Every entry is the sum of the weights whose tap bit is set in its address.
    for (genvar a = 0; a < NE; a++) begin : g_ent
        logic signed [TW-1:0] s;
        always_comb begin
            s = '0;
            for (int i = 0; i < N; i++) begin
                if (((a >> i) & 1) != 0) begin
                    s = s + TW'($signed(w_flat[i*W +: W]));
                end
            end
        end
        assign tbl_flat[a*TW +: TW] = s;
    end

endmodule

// File: rtl/dalms_tap_upd.sv
module dalms_tap_upd #(
    parameter int W  = 16,
    parameter int B  = 8,
    parameter int KW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                first,
    input  logic                xbit,
    input  logic signed [W-1:0] err,
    input  logic [KW-1:0]       k,
    input  logic signed [W-1:0] w_cur,
    output logic signed [W-1:0] w_new
);
    localparam int PW = W + B;

    logic signed [PW-1:0] prod_q;
    logic signed [PW-1:0] addend;
    logic signed [PW-1:0] delta;
    logic signed [31:0]   sum;

    assign addend = xbit ? PW'(err) : '0;

    // MSB-first shift-and-add of err times the stored sample; sign bit subtracts.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else if (step) begin
            prod_q <= first ? -addend : ((prod_q <<< 1) + addend);
        end
    end

    assign delta = prod_q >>> (B - 1 + int'(k));
    assign sum   = dalms_pkg::clip(32'(w_cur) + 32'(delta), W);
    assign w_new = sum[W-1:0];

endmodule

// File: rtl/dalms_filter.sv
module dalms_filter
    import dalms_pkg::*;
#(
    parameter int N  = 4,
    parameter int B  = 8,
    parameter int W  = 16,
    parameter int F  = 12,
    parameter int KW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [B-1:0]  x_in,
    input  logic          x_valid,
    input  logic [B-1:0]  d_in,
    input  logic          d_valid,
    input  logic [KW-1:0] mu_k,
    output logic [W-1:0]  y_out,
    output logic [W-1:0]  e_out,
    output logic          done
);
    localparam int TW = W + $clog2(N);
    localparam int AW = TW + B;
    localparam int NE = 1 << N;
    localparam int CW = (B > 1) ? $clog2(B) : 1;
    localparam int DS = F - (B - 1);

    dalms_state_e st_q, st_d;

    logic [CW-1:0]        bit_q;
    logic [B-1:0]         xd_q [N];
    logic [B-1:0]         xu_q [N];
    logic [B-1:0]         xh_q;
    logic [B-1:0]         dh_q;
    logic [KW-1:0]        kh_q;
    logic [N*W-1:0]       w_q;
    logic [N*W-1:0]       w_nx;
    logic [NE*TW-1:0]     tbl_q;
    logic [NE*TW-1:0]     tbl_nx;
    logic signed [AW-1:0] acc_q;
    logic [N-1:0]         slice;
    logic [N-1:0]         uslice;
    logic signed [TW-1:0] tsel;
    logic                 first_bit;
    logic                 step;
    logic signed [31:0]   y_full, y_sat, e_full, e_sat;

    // Table address straight from one bit of every tap; no address controller.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            slice[i]  = xd_q[i][bit_q];
            uslice[i] = xu_q[i][bit_q];
        end
    end

    assign tsel      = $signed(tbl_q[int'(slice)*TW +: TW]);
    assign step      = (st_q == ST_ACCUM);
    assign first_bit = (bit_q == CW'(B - 1));
    assign y_full    = 32'(acc_q >>> (B - 1));
    assign y_sat     = clip(y_full, W);
    assign e_full    = (32'($signed(dh_q)) <<< DS) - y_sat;
    assign e_sat     = clip(e_full, W);

    for (genvar i = 0; i < N; i++) begin : g_tap
        dalms_tap_upd #(.W(W), .B(B), .KW(KW)) u_upd (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (step),
            .first (first_bit),
            .xbit  (uslice[i]),
            .err   (e_out),
            .k     (kh_q),
            .w_cur (w_q[i*W +: W]),
            .w_new (w_nx[i*W +: W])
        );
    end

    dalms_table #(.N(N), .W(W), .TW(TW)) u_tbl (
        .w_flat   (w_q),
        .tbl_flat (tbl_nx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   st_d = x_valid ? ST_LOAD : ST_IDLE;
            ST_LOAD:   st_d = ST_ACCUM;
            ST_ACCUM:  st_d = (bit_q == '0) ? ST_FINISH : ST_ACCUM;
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                xd_q[i] <= '0;
                xu_q[i] <= '0;
            end
            xh_q  <= '0;
            dh_q  <= '0;
            kh_q  <= '0;
            w_q   <= '0;
            tbl_q <= '0;
            acc_q <= '0;
            bit_q <= '0;
            y_out <= '0;
            e_out <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (d_valid) dh_q <= d_in;
                    if (x_valid) begin
                        xh_q <= x_in;
                        kh_q <= mu_k;
                    end
                end
                ST_LOAD: begin
                    xd_q[0] <= xh_q;
                    for (int i = 1; i < N; i++) xd_q[i] <= xd_q[i-1];
                    for (int i = 0; i < N; i++) xu_q[i] <= xd_q[i];
                    tbl_q <= tbl_nx;
                    bit_q <= CW'(B - 1);
                end
                ST_ACCUM: begin
                    if (first_bit) acc_q <= -AW'(tsel);
                    else           acc_q <= (acc_q <<< 1) + AW'(tsel);
                    bit_q <= bit_q - CW'(1);
                end
                ST_FINISH: begin
                    y_out <= y_sat[W-1:0];
                    e_out <= e_sat[W-1:0];
                    w_q   <= w_nx;
                    done  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R2: strobe lasts one cycle
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: load is followed by the first bit step at the top bit
    assert_load_to_accum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOAD) |=> (st_q == ST_ACCUM && bit_q == CW'(B - 1)));

    // R3: table is frozen while bits are accumulated
    assert_table_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACCUM && $past(st_q) == ST_ACCUM) |-> $stable(tbl_q));

    // R3: single-tap entry matches the live weight of tap 0 during accumulation
    assert_table_tap0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACCUM) |-> ($signed(tbl_q[TW +: TW]) == TW'($signed(w_q[W-1:0]))));

    // R5: weights move only at the end of a sample
    assert_weights_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_FINISH) |=> $stable(w_q));

    // R9: held sample and step exponent untouched while busy
    assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> ($stable(xh_q) && $stable(kh_q)));

endmodule

// File: tb/dalms_filter_bench.sv
module dalms_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int B = 8;
    localparam int W = 16;
    localparam int F = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [B-1:0] x_in = '0;
    logic         x_valid = 1'b0;
    logic [B-1:0] d_in = '0;
    logic         d_valid = 1'b0;
    logic [2:0]   mu_k = '0;
    logic [W-1:0] y_out;
    logic [W-1:0] e_out;
    logic         done;

    int checks = 0;
    int bad = 0;
    int mw[N];
    int mx[N];
    int px[N];
    int pe = 0;
    int md = 0;
    int seed = 12345;

    always #(CLK_PERIOD/2) clk = ~clk;

    dalms_filter u_dalms_filter (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .x_valid(x_valid),
        .d_in(d_in), .d_valid(d_valid), .mu_k(mu_k),
        .y_out(y_out), .e_out(e_out), .done(done)
    );

    function automatic int clampw(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int next_rand();
        seed = seed * 1103515245 + 12345;
        return ((seed >> 8) & 255) - 128;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // One sample through the block, with the model stepped alongside.
    task automatic send(int x, int d, bit dv, int k, bit noise, string tag);
        int acc;
        int y;
        int e;
        bit yc;
        @(negedge clk);
        x_in = x[7:0]; x_valid = 1'b1; d_in = d[7:0]; d_valid = dv; mu_k = k[2:0];
        if (dv) md = d;
        for (int i = N - 1; i > 0; i--) mx[i] = mx[i-1];
        mx[0] = x;
        acc = 0;
        for (int i = 0; i < N; i++) acc += mw[i] * mx[i];
        y  = clampw(acc >>> (B - 1));
        yc = (y != (acc >>> (B - 1)));
        e  = clampw(md * (1 << (F - B + 1)) - y);
        for (int i = 0; i < N; i++) mw[i] = clampw(mw[i] + ((pe * px[i]) >>> (B - 1 + k)));
        pe = e;
        for (int i = 0; i < N; i++) px[i] = mx[i];
        for (int c = 1; c <= B + 3; c++) begin
            @(negedge clk);
            if (c == 1) begin x_valid = 1'b0; d_valid = 1'b0; end
            if (noise && c >= 2 && c <= 6) begin
                x_valid = (c != 6); d_valid = (c != 6);
                x_in = 8'h5a ^ 8'(c); d_in = 8'h81; mu_k = 3'd7;
            end
            check("R2", "done", int'(done), (c == B + 3) ? 1 : 0);
        end
        check(yc ? "R7" : tag, "y", int'($signed(y_out)), y);
        check(noise ? "R9" : "R4", "e", int'($signed(e_out)), e);
    endtask

    task automatic load_d(int d);
        @(negedge clk);
        d_in = d[7:0]; d_valid = 1'b1;
        @(negedge clk);
        d_valid = 1'b0;
        md = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; bad++;
        $display("FAIL R2 watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin mw[i] = 0; mx[i] = 0; px[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check("R8", "y", int'($signed(y_out)), 0);
        check("R8", "e", int'($signed(e_out)), 0);
        check("R8", "done", int'(done), 0);
        // R8: first sample sees zero weights
        send(100, 50, 1'b1, 3, 1'b0, "R8");
        // R3 / R4 / R5: random training
        for (int n = 0; n < 16; n++) send(next_rand(), next_rand(), 1'b1, 3, 1'b0, "R3");
        // R5: every step exponent
        for (int n = 0; n < 8; n++) send(next_rand(), next_rand(), 1'b1, n, 1'b0, "R5");
        // R9: input toggling while busy
        for (int n = 0; n < 3; n++) send(next_rand(), next_rand(), 1'b1, 2, 1'b1, "R9");
        // R1: held desired value, stored alone and reused
        load_d(-77);
        send(40, 0, 1'b0, 2, 1'b0, "R1");
        send(-90, 0, 1'b0, 2, 1'b0, "R1");
        // R6: large steps drive the weights to their limits
        for (int n = 0; n < 12; n++) send(127, 127, 1'b1, 0, 1'b0, "R6");
        for (int n = 0; n < 6; n++) send(-128, -128, 1'b1, 0, 1'b0, "R6");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule